// File: doc/BRIEF.md
# Multi-Size Integer Adder with Status Flags

This block is the integer add slice of a general-purpose execute stage. It adds a destination operand to a source operand and returns the sum at one of four operand widths: 8, 16, 32 or 64 bits. The source is either a register value or an immediate. An immediate arrives as a short 8-bit field or a long 32-bit field and is sign-extended to the active width before the add. Bits above the active width are cleared in the result.

Alongside the sum the block returns six status flags: carry, parity, auxiliary (nibble) carry, zero, sign and signed overflow. All six are updated by every completed add. A locked request whose destination is not a memory operand is refused. In that case the block reports a lock fault in place of a normal result.

Results are registered. A one-cycle input valid pulse yields a one-cycle output valid pulse on the next clock edge. The result and flags then hold until the next operation. The upstream decoder drives the operand width, the immediate form and the lock qualifiers directly.

Top module: `szadd_top`

## Requirements
- R1: `sumOut` equals `dstVal + source` truncated to the active width, and every bit of `sumOut` above that width reads 0.
- R2: The active width follows `opSel`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. When `wideOp` is 1 the width is 64 bits whatever `opSel` holds.
- R3: With `srcIsImm`=1 the source is the immediate and `srcReg` is ignored. With `immWide`=0 the immediate is `immVal[7:0]` sign-extended; with `immWide`=1 it is `immVal[31:0]` sign-extended. The extended value is then cut to the active width.
- R4: `flagCarry` is the unsigned carry out of the most significant bit of the active width.
- R5: `flagOvf` is 1 when both operands have the same sign at the active width and the result's sign differs from it.
- R6: `flagSign` equals the result's most significant bit at the active width. `flagZero` is 1 exactly when the truncated result is zero.
- R7: `flagAux` is the carry from bit 3 into bit 4. `flagParity` is 1 when `sumOut[7:0]` holds an even number of ones.
- R8: `outValid` is 1 in exactly the cycle after each cycle in which `inValid` is 1, and 0 otherwise. Between operations, `sumOut` and the flags hold their last value.
- R9: An operation with `lockReq`=1 and `dstIsMem`=0 completes with `outValid`=1 and `lockFault`=1, `sumOut`=0 and all six flags 0. With `lockReq`=1 and `dstIsMem`=1 the add completes normally and `lockFault` stays 0.
- R10: After reset, `outValid`, `lockFault`, `sumOut` and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation request, one cycle per add |
| dstVal | input | 64 | Destination operand |
| srcReg | input | 64 | Register source operand |
| immVal | input | 32 | Immediate field; low byte used in short form |
| srcIsImm | input | 1 | 1 selects the immediate as source |
| immWide | input | 1 | 1 = 32-bit immediate, 0 = 8-bit immediate |
| opSel | input | 2 | Width code: 0=8, 1=16, 2/3=32 bits |
| wideOp | input | 1 | Forces 64-bit width |
| lockReq | input | 1 | Locked operation requested |
| dstIsMem | input | 1 | Destination is a memory operand |
| outValid | output | 1 | Result valid pulse |
| sumOut | output | 64 | Zero-extended truncated sum |
| flagCarry | output | 1 | Unsigned carry |
| flagParity | output | 1 | Even parity of the low byte |
| flagAux | output | 1 | Carry from bit 3 to bit 4 |
| flagZero | output | 1 | Result is zero |
| flagSign | output | 1 | Result sign |
| flagOvf | output | 1 | Signed overflow |
| lockFault | output | 1 | Locked operation refused |

## Verification
The bench aims at sign boundaries at each width, such as 0x7F+1 in a byte and 0x7FFF…+1 at 64 bits. A design that took the sign or carry from a fixed bit would report the wrong overflow, carry or sign there. Negative 8-bit and 32-bit immediates at 64-bit width catch zero-extension in place of sign-extension, which shows up as a wrong upper half and a missing carry. The width override (`wideOp` with `opSel`=0) and the reserved `opSel` code 3 expose a faulty width decode. Junk in the upper destination bits shows whether truncation leaks into the result or into the zero flag. Lock requests with and without a memory destination show whether the fault gating is wrong: a design that got it wrong would either refuse a legal add or let a refused one write results.

// File: rtl/szadd_pkg.sv
package szadd_pkg;

  // Active operand width; the code is also the lane index in the datapath.
  typedef enum logic [1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } opSize_e;

  localparam int NUM_SIZES = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    loadResult;
    logic    loadFault;
    opSize_e size;
  } ctrlStrobe_t;

endpackage

// File: rtl/szadd_ctrl.sv
module szadd_ctrl
  import szadd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opSel,
  input  logic        wideOp,
  input  logic        lockReq,
  input  logic        dstIsMem,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        lockFault
);

  opSize_e sizeDec;
  logic    faultNow;
  logic    validQ;
  logic    faultQ;

  // Width decode: the explicit wide control wins, code 3 falls back to 32.
  always_comb begin
    if (wideOp) begin
      sizeDec = SZ64;
    end else begin
      unique case (opSel)
        2'd0:    sizeDec = SZ8;
        2'd1:    sizeDec = SZ16;
        default: sizeDec = SZ32;
      endcase
    end
  end

  assign faultNow = lockReq & ~dstIsMem;

  always_comb begin
    strobe.loadResult = inValid & ~faultNow;
    strobe.loadFault  = inValid & faultNow;
    strobe.size       = sizeDec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      validQ <= inValid;
      faultQ <= inValid & faultNow;
    end
  end

  assign outValid  = validQ;
  assign lockFault = faultQ;

  // R8: a request produces a result pulse on the next edge
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R8: no request, no pulse
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R9: locked register destination is refused
  a_r9_fault_raised: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lockReq && !dstIsMem) |=> (lockFault && outValid));

  // R9: locked memory destination completes normally
  a_r9_mem_lock_ok: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lockReq && dstIsMem) |=> !lockFault);

  // R9: a fault never shows without a result pulse
  a_r9_fault_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    lockFault |-> outValid);

endmodule

// File: rtl/szadd_dp.sv
module szadd_dp
  import szadd_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int IMM_W       = 32,
  parameter int IMM_SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcReg,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              srcIsImm,
  input  logic              immWide,
  output logic [DATA_W-1:0] sumOut,
  output logic              flagCarry,
  output logic              flagParity,
  output logic              flagAux,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOvf
);

  localparam int BYTE_W = DATA_W >> (NUM_SIZES - 1);

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] laneSum   [NUM_SIZES];
  logic              laneCarry [NUM_SIZES];
  logic              laneOvf   [NUM_SIZES];
  logic              laneSign  [NUM_SIZES];

  logic [DATA_W-1:0] resNext;
  logic              cfNext, ofNext, sfNext, zfNext, afNext, pfNext;

  logic [DATA_W-1:0] sumQ;
  logic              cfQ, pfQ, afQ, zfQ, sfQ, ofQ;
  opSize_e           sizeQ;

  // Immediate sign extension to full width; lanes truncate afterwards.
  assign immExt = immWide
    ? {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal}
    : {{(DATA_W-IMM_SHORT_W){immVal[IMM_SHORT_W-1]}}, immVal[IMM_SHORT_W-1:0]};

  assign opB = srcIsImm ? immExt : srcReg;

  // One adder lane per operand width, each with its own carry and sign.
  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
    localparam int LW = DATA_W >> (NUM_SIZES - 1 - i);
    logic [LW:0] wideSum;
    assign wideSum      = {1'b0, dstVal[LW-1:0]} + {1'b0, opB[LW-1:0]};
    assign laneSum[i]   = DATA_W'(wideSum[LW-1:0]);
    assign laneCarry[i] = wideSum[LW];
    assign laneSign[i]  = wideSum[LW-1];
    assign laneOvf[i]   = (dstVal[LW-1] == opB[LW-1]) &&
                          (wideSum[LW-1] != dstVal[LW-1]);
  end

  always_comb begin
    resNext = laneSum[strobe.size];
    cfNext  = laneCarry[strobe.size];
    sfNext  = laneSign[strobe.size];
    ofNext  = laneOvf[strobe.size];
    zfNext  = (resNext == '0);
    afNext  = dstVal[4] ^ opB[4] ^ resNext[4];
    pfNext  = ~^resNext[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadFault) begin
      sumQ  <= '0;
      cfQ   <= 1'b0;
      pfQ   <= 1'b0;
      afQ   <= 1'b0;
      zfQ   <= 1'b0;
      sfQ   <= 1'b0;
      ofQ   <= 1'b0;
      sizeQ <= SZ8;
    end else if (strobe.loadResult) begin
      sumQ  <= resNext;
      cfQ   <= cfNext;
      pfQ   <= pfNext;
      afQ   <= afNext;
      zfQ   <= zfNext;
      sfQ   <= sfNext;
      ofQ   <= ofNext;
      sizeQ <= strobe.size;
    end
  end

  assign sumOut     = sumQ;
  assign flagCarry  = cfQ;
  assign flagParity = pfQ;
  assign flagAux    = afQ;
  assign flagZero   = zfQ;
  assign flagSign   = sfQ;
  assign flagOvf    = ofQ;

  function automatic logic signAt(input logic [DATA_W-1:0] v, input opSize_e s);
    unique case (s)
      SZ8:     signAt = v[BYTE_W-1];
      SZ16:    signAt = v[2*BYTE_W-1];
      SZ32:    signAt = v[4*BYTE_W-1];
      default: signAt = v[DATA_W-1];
    endcase
  endfunction

  // R1: byte result never leaks into the upper bits
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadResult && strobe.size == SZ8) |=> (sumOut[DATA_W-1:BYTE_W] == '0));

  // R6: sign flag tracks the registered result at its width
  a_r6_sign_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult |=> (flagSign == signAt(sumOut, sizeQ)));

  // R6: zero flag agrees with the registered result
  a_r6_zero_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult |=> (flagZero == (sumOut == '0)));

  // R7: parity flag agrees with the low byte
  a_r7_parity_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult |=> (flagParity == ~^sumOut[7:0]));

  // R9: refused operation clears result and flags
  a_r9_fault_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFault |=> (sumOut == '0 && !flagCarry && !flagOvf && !flagZero));

  // R8: idle cycles keep the result stable
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadResult && !strobe.loadFault) |=> $stable(sumOut));

endmodule

// File: rtl/szadd_top.sv
module szadd_top
  import szadd_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int IMM_W       = 32,
  parameter int IMM_SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [DATA_W-1:0] srcReg,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              srcIsImm,
  input  logic              immWide,
  input  logic [1:0]        opSel,
  input  logic              wideOp,
  input  logic              lockReq,
  input  logic              dstIsMem,
  output logic              outValid,
  output logic [DATA_W-1:0] sumOut,
  output logic              flagCarry,
  output logic              flagParity,
  output logic              flagAux,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOvf,
  output logic              lockFault
);

  ctrlStrobe_t strobe;

  szadd_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .wideOp   (wideOp),
    .lockReq  (lockReq),
    .dstIsMem (dstIsMem),
    .strobe   (strobe),
    .outValid (outValid),
    .lockFault(lockFault)
  );

  szadd_dp #(
    .DATA_W     (DATA_W),
    .IMM_W      (IMM_W),
    .IMM_SHORT_W(IMM_SHORT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dstVal    (dstVal),
    .srcReg    (srcReg),
    .immVal    (immVal),
    .srcIsImm  (srcIsImm),
    .immWide   (immWide),
    .sumOut    (sumOut),
    .flagCarry (flagCarry),
    .flagParity(flagParity),
    .flagAux   (flagAux),
    .flagZero  (flagZero),
    .flagSign  (flagSign),
    .flagOvf   (flagOvf)
  );

endmodule

// File: tb/szadd_tb_top.sv
`timescale 1ns/100ps
module szadd_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] dstVal = '0;
  logic [63:0] srcReg = '0;
  logic [31:0] immVal = '0;
  logic        srcIsImm = 1'b0;
  logic        immWide = 1'b0;
  logic [1:0]  opSel = 2'd2;
  logic        wideOp = 1'b0;
  logic        lockReq = 1'b0;
  logic        dstIsMem = 1'b0;
  logic        outValid, lockFault;
  logic [63:0] sumOut;
  logic        flagCarry, flagParity, flagAux, flagZero, flagSign, flagOvf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  szadd_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dstVal(dstVal), .srcReg(srcReg),
    .immVal(immVal), .srcIsImm(srcIsImm), .immWide(immWide), .opSel(opSel),
    .wideOp(wideOp), .lockReq(lockReq), .dstIsMem(dstIsMem), .outValid(outValid),
    .sumOut(sumOut), .flagCarry(flagCarry), .flagParity(flagParity), .flagAux(flagAux),
    .flagZero(flagZero), .flagSign(flagSign), .flagOvf(flagOvf), .lockFault(lockFault)
  );

  // Vector fields: dst[164:101] src[100:37] imm[36:5] isImm[4] immWide[3] opSel[2:1] wide[0]
  localparam int VW = 165;
  localparam int NV = 16;
  localparam logic [VW-1:0] VECS [NV] = '{
    {64'hFFFF_FFFF_FFFF_FF7F, 64'h0000_0000_0000_0001, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0},
    {64'h0000_0000_0000_00FF, 64'hAAAA_AAAA_AAAA_AA01, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0},
    {64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 32'h0, 1'b0, 1'b0, 2'd1, 1'b0},
    {64'h1234_5678_FFFF_FFFF, 64'h0000_0000_0000_0001, 32'h0, 1'b0, 1'b0, 2'd2, 1'b0},
    {64'h0000_0000_1234_5678, 64'h0000_0000_1111_1111, 32'h0, 1'b0, 1'b0, 2'd3, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 32'h0, 1'b0, 1'b0, 2'd2, 1'b1},
    {64'h0000_0000_0000_0005, 64'h0, 32'h0000_00FF, 1'b1, 1'b0, 2'd2, 1'b1},
    {64'h0000_0000_0000_0000, 64'hFFFF, 32'h8000_0000, 1'b1, 1'b1, 2'd2, 1'b1},
    {64'h0000_0000_0000_0100, 64'h0, 32'h0000_0080, 1'b1, 1'b0, 2'd2, 1'b0},
    {64'h0000_0000_0000_7FFF, 64'h0, 32'h0000_007F, 1'b1, 1'b0, 2'd1, 1'b0},
    {64'h0000_0000_0000_007F, 64'h0, 32'h1234_5601, 1'b1, 1'b1, 2'd0, 1'b0},
    {64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 32'h0, 1'b0, 1'b0, 2'd2, 1'b1},
    {64'h0000_0001_0000_00F0, 64'h0000_0001_0000_0020, 32'h0, 1'b0, 1'b0, 2'd0, 1'b1},
    {64'hFFFF_FFFF_FFFF_0003, 64'h0000_0000_0001_0000, 32'h0, 1'b0, 1'b0, 2'd1, 1'b0},
    {64'h0000_0000_7FFF_FFF0, 64'hDEAD_BEEF_DEAD_BEEF, 32'h0000_0010, 1'b1, 1'b1, 2'd2, 1'b0},
    {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211, 32'h0, 1'b0, 1'b0, 2'd2, 1'b1}
  };

  typedef struct {
    logic [63:0] sum;
    logic cf, pf, af, zf, sf, ofl;
  } refRes_t;

  // Independent model: 128-bit arithmetic with masks.
  function automatic refRes_t refAdd(input logic [63:0] d, input logic [63:0] s,
                                     input logic [31:0] im, input logic isImm,
                                     input logic imW, input logic [1:0] sel, input logic w);
    refRes_t r;
    int width;
    logic [127:0] mask, a, b, t, msb, res;
    logic [63:0] srcv;
    int ones;
    width = w ? 64 : (sel == 2'd0 ? 8 : (sel == 2'd1 ? 16 : 32));
    if (isImm) srcv = imW ? 64'($signed(im)) : 64'($signed(im[7:0]));
    else       srcv = s;
    mask = (128'd1 << width) - 128'd1;
    msb  = 128'd1 << (width - 1);
    a = {64'd0, d} & mask;
    b = {64'd0, srcv} & mask;
    t = a + b;
    res = t & mask;
    r.sum = res[63:0];
    r.cf  = ((t >> width) & 128'd1) != 0;
    r.ofl = (((a ^ res) & (b ^ res) & msb) != 0);
    r.sf  = ((res & msb) != 0);
    r.zf  = (res == 0);
    r.af  = (((a ^ b ^ res) >> 4) & 128'd1) != 0;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(res[k]);
    r.pf  = (ones % 2) == 0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                      input logic isImm, input logic imW, input logic [1:0] sel,
                      input logic w, input logic lk, input logic mem);
    @(negedge clk);
    dstVal = d; srcReg = s; immVal = im; srcIsImm = isImm; immWide = imW;
    opSel = sel; wideOp = w; lockReq = lk; dstIsMem = mem; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; lockReq = 1'b0;
  endtask

  task automatic chkFlags(input string id, input refRes_t e);
    chk({id, " R1 R2 R3 sum"}, sumOut, e.sum);
    chk({id, " R4 carry"}, 64'(flagCarry), 64'(e.cf));
    chk({id, " R5 overflow"}, 64'(flagOvf), 64'(e.ofl));
    chk({id, " R6 sign"}, 64'(flagSign), 64'(e.sf));
    chk({id, " R6 zero"}, 64'(flagZero), 64'(e.zf));
    chk({id, " R7 aux"}, 64'(flagAux), 64'(e.af));
    chk({id, " R7 parity"}, 64'(flagParity), 64'(e.pf));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    refRes_t e;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 outValid", 64'(outValid), 64'd0);
    chk("R10 lockFault", 64'(lockFault), 64'd0);
    chk("R10 sum", sumOut, 64'd0);
    chk("R10 flags", {58'd0, flagCarry, flagParity, flagAux, flagZero, flagSign, flagOvf}, 64'd0);

    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VECS[k];
      fire(v[164:101], v[100:37], v[36:5], v[4], v[3], v[2:1], v[0], 1'b0, 1'b0);
      e = refAdd(v[164:101], v[100:37], v[36:5], v[4], v[3], v[2:1], v[0]);
      chk($sformatf("vec%0d R8 valid", k), 64'(outValid), 64'd1);
      chkFlags($sformatf("vec%0d", k), e);
      held = sumOut;
      @(negedge clk);
      chk($sformatf("vec%0d R8 pulse ends", k), 64'(outValid), 64'd0);
      chk($sformatf("vec%0d R8 hold", k), sumOut, held);
    end

    // R9: locked add to a register destination is refused
    fire(64'h10, 64'h20, 32'h0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0);
    chk("R9 fault valid", 64'(outValid), 64'd1);
    chk("R9 fault flag", 64'(lockFault), 64'd1);
    chk("R9 fault sum", sumOut, 64'd0);
    chk("R9 fault flags", {58'd0, flagCarry, flagParity, flagAux, flagZero, flagSign, flagOvf}, 64'd0);
    @(negedge clk);
    chk("R9 fault pulse ends", 64'(lockFault), 64'd0);

    // R9: locked add to memory destination completes
    fire(64'hFF, 64'h01, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
    e = refAdd(64'hFF, 64'h01, 32'h0, 1'b0, 1'b0, 2'd0, 1'b0);
    chk("R9 mem lock no fault", 64'(lockFault), 64'd0);
    chkFlags("R9 mem lock", e);

    // R8: back-to-back requests give back-to-back results
    @(negedge clk);
    dstVal = 64'h1; srcReg = 64'h2; srcIsImm = 1'b0; opSel = 2'd2; wideOp = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    chk("R8 b2b first", sumOut, 64'h3);
    dstVal = 64'h7FFF; srcReg = 64'h1; opSel = 2'd1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 b2b second valid", 64'(outValid), 64'd1);
    chk("R8 b2b second", sumOut, 64'h8000);
    chk("R5 b2b ovf", 64'(flagOvf), 64'd1);

    // R3: srcReg ignored with immediate source
    fire(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0002, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
    chk("R3 srcReg ignored", sumOut, 64'h2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule